// File: doc/BRIEF.md
# Serial Flash User-Mode Transfer Engine

This block is a register-programmed SPI master for a serial flash port. Software loads up to 64 bytes into a word-addressed data buffer, programs a bit count, polarity and chip-select options, and sets a start bit. The engine then shifts the buffer out on MOSI, most significant bit of each byte first, and can sample MISO back into the same buffer positions as it goes. Software polls a sticky done flag to learn when the transfer is over, then reads the received bytes from the buffer.

A chip-select hold option keeps the select line asserted after a transfer ends. Several buffer-sized chunks can then form one flash transaction: software sets hold for every chunk except the last. The clock runs in mode 0 timing relative to its idle level: MISO is sampled on the leading SCLK edge and MOSI changes on the trailing edge. The idle level itself is programmable. A self-clearing soft reset aborts a transfer, and a mode bit blocks starts whenever it is not zero (master).

The sequencer has five states. IDLE goes to SETUP on an accepted start. SETUP goes to LEAD after one half period; SETUP drives the first bit with the clock idle. LEAD, with the clock at its active level, goes to TRAIL when more bits remain and to END after the last bit. TRAIL, with the clock back at idle, goes to LEAD. END goes to IDLE after one half period, and on that step it sets done. A soft reset sends any state straight to IDLE. Each state lasts `HALF_DIV` clock cycles.

Top module: `sfc_user_engine`

## Requirements
- R1: The buffer is sixteen 32-bit words at byte offsets 0x40..0x7C. Transfer byte k lives in word k/4, byte lane k%4 (lane 0 = bits 7:0). Each byte is shifted out MSB first.
- R2: Writing a 1 to bit 18 at offset 0x00 while idle starts a transfer, and chip select becomes active on the next cycle.
- R3: The field at bits 25:17 of offset 0x20 holds the bit count minus one (8n-1 for n bytes). The transfer produces exactly that many plus one leading SCLK edges.
- R4: When bit 0 of offset 0x1C is 1, each MISO bit overwrites the buffer bit whose value was transmitted in that slot. When it is 0, the buffer is unchanged.
- R5: Bit 4 of offset 0x30 is a done flag that is 0 after reset. The engine sets it after the last bit, and software writes it to 0 to clear it.
- R6: If bit 30 of offset 0x2C is 1, chip select stays active after the transfer ends. If it is 0, chip select is released at the end.
- R7: Bit 23 of offset 0x2C set makes chip select active-high; clear makes it active-low.
- R8: Bit 7 of offset 0x1C gives the SCLK idle level. SCLK sits at that level whenever no transfer runs.
- R9: During a transfer, MOSI changes only at a trailing SCLK edge. The MISO value present before a leading edge is the one captured.
- R10: Writing a 1 to bit 31 of offset 0x30 returns the engine to IDLE and releases chip select, even with hold set. The bit reads back 0.
- R11: Bit 30 of offset 0x30 reads back as written. While it is 1, start commands are ignored.
- R12: A start command written during a transfer is ignored, and the running transfer is neither restarted nor lengthened.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 7 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| spi_sclk | output | 1 | Serial clock |
| spi_cs | output | 1 | Chip select, polarity per R7 |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
The shift path is tried with a 4-byte mixed pattern, a single byte inside a fuller word, and a full 64-byte computed pattern. These separate errors in byte-lane order, bit order and end-of-count handling. Running with capture disabled shows that transmit data survives in the buffer. Running with inverted clock and select polarity shows that edge roles follow the idle level rather than fixed rising or falling edges. A two-chunk run with hold proves the slave sees one unbroken select window with continuous data. Soft reset, the non-master mode and a mid-transfer restart each show that the engine leaves the bus as the requirements demand.

// File: rtl/sfc_pkg.sv
`timescale 1ns/1ps
package sfc_pkg;
    localparam logic [6:0] OFS_CMD   = 7'h00;
    localparam logic [6:0] OFS_USER  = 7'h1C;
    localparam logic [6:0] OFS_LEN   = 7'h20;
    localparam logic [6:0] OFS_CSCTL = 7'h2C;
    localparam logic [6:0] OFS_STAT  = 7'h30;

    localparam int B_START   = 18;
    localparam int B_DIN_EN  = 0;
    localparam int B_CPOL    = 7;
    localparam int B_LEN_LO  = 17;
    localparam int B_CS_HIGH = 23;
    localparam int B_HOLD    = 30;
    localparam int B_DONE    = 4;
    localparam int B_MODE    = 30;
    localparam int B_SRST    = 31;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SETUP,
        S_LEAD,
        S_TRAIL,
        S_END
    } sfc_state_e;
endpackage

// File: rtl/sfc_half_timer.sv
`timescale 1ns/1ps
module sfc_half_timer #(
    parameter int HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

    logic [CW-1:0] ctr_q;

    assign tick = !clr && (ctr_q == CW'(HALF - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ctr_q <= '0;
        else if (clr || tick)
            ctr_q <= '0;
        else
            ctr_q <= ctr_q + 1'b1;
    end
endmodule

// File: rtl/sfc_shift_fsm.sv
`timescale 1ns/1ps
module sfc_shift_fsm
    import sfc_pkg::*;
#(
    parameter int IDX_W = 9,
    parameter int HALF  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             srst,
    input  logic             start,
    input  logic             hold,
    input  logic [IDX_W-1:0] len,
    output logic             accept,
    output logic             sample,
    output logic             advance,
    output logic             finish,
    output logic             busy,
    output logic             sclk_act,
    output logic             cs_on,
    output logic [IDX_W-1:0] cnt
);
    sfc_state_e state_q, state_d;
    logic       tick;
    logic       last_bit;

    sfc_half_timer #(.HALF(HALF)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (state_q == S_IDLE),
        .tick (tick)
    );

    assign last_bit = (cnt == len);

    // next state
    always_comb begin
        state_d = state_q;
        if (srst) begin
            state_d = S_IDLE;
        end else begin
            unique case (state_q)
                S_IDLE:  if (start) state_d = S_SETUP;
                S_SETUP: if (tick)  state_d = S_LEAD;
                S_LEAD:  if (tick)  state_d = last_bit ? S_END : S_TRAIL;
                S_TRAIL: if (tick)  state_d = S_LEAD;
                S_END:   if (tick)  state_d = S_IDLE;
                default:            state_d = S_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        accept   = !srst && (state_q == S_IDLE) && start;
        sample   = !srst && tick && ((state_q == S_SETUP) || (state_q == S_TRAIL));
        advance  = !srst && tick && (state_q == S_LEAD) && !last_bit;
        finish   = !srst && tick && (state_q == S_END);
        busy     = (state_q != S_IDLE);
        sclk_act = (state_q == S_LEAD);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            cs_on <= 1'b0;
        end else begin
            if (accept)       cnt <= '0;
            else if (advance) cnt <= cnt + 1'b1;

            if (srst)                 cs_on <= 1'b0;
            else if (accept)          cs_on <= 1'b1;
            else if (finish && !hold) cs_on <= 1'b0;
        end
    end
endmodule

// File: rtl/sfc_user_engine.sv
`timescale 1ns/1ps
module sfc_user_engine
    import sfc_pkg::*;
#(
    parameter int HALF_DIV  = 2,
    parameter int BUF_WORDS = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_we,
    input  logic [6:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        spi_sclk,
    output logic        spi_cs,
    output logic        spi_mosi,
    input  logic        spi_miso
);
    localparam int BUF_BITS = BUF_WORDS * 32;
    localparam int IDX_W    = $clog2(BUF_BITS);
    localparam int WSEL_W   = $clog2(BUF_WORDS);

    logic             din_en_q, cpol_q, cs_high_q, hold_q, mode_q, done_q, mosi_q;
    logic [IDX_W-1:0] len_q;
    logic [BUF_BITS-1:0] buf_q;

    logic             accept, sample, advance, finish, busy, sclk_act, cs_on;
    logic [IDX_W-1:0] cnt, cnt_nxt;
    logic             wr_cmd, wr_user, wr_len, wr_csctl, wr_stat, wr_buf;
    logic             srst, start_req;
    logic [WSEL_W-1:0] wsel;
    logic             unused_bus;

    assign unused_bus = ^{bus_wdata, bus_addr};

    // byte k bit j (MSB first order) sits at flat position 8k + (7 - j)
    function automatic logic [IDX_W-1:0] bit_pos(input logic [IDX_W-1:0] b);
        return {b[IDX_W-1:3], ~b[2:0]};
    endfunction

    assign wr_cmd   = bus_we && (bus_addr == OFS_CMD);
    assign wr_user  = bus_we && (bus_addr == OFS_USER);
    assign wr_len   = bus_we && (bus_addr == OFS_LEN);
    assign wr_csctl = bus_we && (bus_addr == OFS_CSCTL);
    assign wr_stat  = bus_we && (bus_addr == OFS_STAT);
    assign wr_buf   = bus_we && bus_addr[6];
    assign wsel     = bus_addr[WSEL_W+1:2];

    assign srst      = wr_stat && bus_wdata[B_SRST];
    assign start_req = wr_cmd && bus_wdata[B_START] && !mode_q;
    assign cnt_nxt   = cnt + 1'b1;

    sfc_shift_fsm #(.IDX_W(IDX_W), .HALF(HALF_DIV)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .srst    (srst),
        .start   (start_req),
        .hold    (hold_q),
        .len     (len_q),
        .accept  (accept),
        .sample  (sample),
        .advance (advance),
        .finish  (finish),
        .busy    (busy),
        .sclk_act(sclk_act),
        .cs_on   (cs_on),
        .cnt     (cnt)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            din_en_q  <= 1'b0;
            cpol_q    <= 1'b0;
            len_q     <= '0;
            cs_high_q <= 1'b0;
            hold_q    <= 1'b0;
            mode_q    <= 1'b0;
            done_q    <= 1'b0;
        end else begin
            if (wr_user) begin
                din_en_q <= bus_wdata[B_DIN_EN];
                cpol_q   <= bus_wdata[B_CPOL];
            end
            if (wr_len) len_q <= bus_wdata[B_LEN_LO +: IDX_W];
            if (wr_csctl) begin
                cs_high_q <= bus_wdata[B_CS_HIGH];
                hold_q    <= bus_wdata[B_HOLD];
            end
            if (wr_stat) mode_q <= bus_wdata[B_MODE];
            if (finish)       done_q <= 1'b1;
            else if (wr_stat) done_q <= bus_wdata[B_DONE];
        end
    end

    // buffer: engine capture wins over a bus write to the same bit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_q  <= '0;
            mosi_q <= 1'b0;
        end else begin
            if (wr_buf) buf_q[{wsel, 5'b0} +: 32] <= bus_wdata;
            if (sample && din_en_q) buf_q[bit_pos(cnt)] <= spi_miso;
            if (accept)       mosi_q <= buf_q[bit_pos('0)];
            else if (advance) mosi_q <= buf_q[bit_pos(cnt_nxt)];
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr[6]) begin
            bus_rdata = buf_q[{wsel, 5'b0} +: 32];
        end else begin
            case (bus_addr)
                OFS_USER: begin
                    bus_rdata[B_DIN_EN] = din_en_q;
                    bus_rdata[B_CPOL]   = cpol_q;
                end
                OFS_LEN:  bus_rdata[B_LEN_LO +: IDX_W] = len_q;
                OFS_CSCTL: begin
                    bus_rdata[B_CS_HIGH] = cs_high_q;
                    bus_rdata[B_HOLD]    = hold_q;
                end
                OFS_STAT: begin
                    bus_rdata[B_DONE] = done_q;
                    bus_rdata[B_MODE] = mode_q;
                end
                default: bus_rdata = '0;
            endcase
        end
    end

    assign spi_sclk = cpol_q ^ sclk_act;
    assign spi_cs   = cs_high_q ? cs_on : ~cs_on;
    assign spi_mosi = mosi_q;
endmodule

// File: rtl/sfc_user_engine_chk.sv
`timescale 1ns/1ps
module sfc_user_engine_chk #(
    parameter int IDX_W = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             accept,
    input logic             finish,
    input logic             srst,
    input logic             done,
    input logic             cpol,
    input logic             cs_high,
    input logic [IDX_W-1:0] len,
    input logic             sclk,
    input logic             cs,
    input logic             mosi
);
    logic [IDX_W:0] lead_cnt;
    logic           prev_sclk;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lead_cnt  <= '0;
            prev_sclk <= 1'b0;
        end else begin
            prev_sclk <= sclk;
            if (accept)
                lead_cnt <= '0;
            else if (busy && (sclk != cpol) && (prev_sclk == cpol))
                lead_cnt <= lead_cnt + 1'b1;
        end
    end

    assert_cs_on_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (cs == cs_high));

    assert_edge_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
        finish |-> (lead_cnt == ({1'b0, len} + 1'b1)));

    assert_done_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        finish |=> done);

    assert_idle_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (sclk == cpol));

    assert_mosi_trailing_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && !$stable(mosi)) |-> ((sclk == cpol) && ($past(sclk) != cpol)));

    assert_srst_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> (!busy && (cs != cs_high)));
endmodule

bind sfc_user_engine sfc_user_engine_chk #(.IDX_W(IDX_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .busy   (busy),
    .accept (accept),
    .finish (finish),
    .srst   (srst),
    .done   (done_q),
    .cpol   (cpol_q),
    .cs_high(cs_high_q),
    .len    (len_q),
    .sclk   (spi_sclk),
    .cs     (spi_cs),
    .mosi   (spi_mosi)
);

// File: tb/sfc_user_engine_tb.sv
`timescale 1ns/1ps
module sfc_user_engine_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [6:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        spi_sclk, spi_cs, spi_mosi, spi_miso;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    sfc_user_engine u_dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_sclk(spi_sclk),
        .spi_cs(spi_cs), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    // ---------------- slave model ----------------
    logic [7:0] slv_tx [64];
    logic [7:0] slv_rx [64];
    int  lead_cnt = 0, rx_cnt = 0, tx_cnt = 0, cs_rel = 0;
    logic tb_cpol = 1'b0, tb_cshigh = 1'b0;
    logic prev_sclk = 1'b0, prev_act = 1'b0;
    logic cs_act;

    assign cs_act   = (spi_cs === tb_cshigh);
    assign spi_miso = slv_tx[(tx_cnt / 8) % 64][7 - (tx_cnt % 8)];

    always @(negedge clk) begin
        if (cs_act && (spi_sclk !== prev_sclk)) begin
            if (spi_sclk !== tb_cpol) begin
                lead_cnt = lead_cnt + 1;
                slv_rx[(rx_cnt / 8) % 64][7 - (rx_cnt % 8)] = spi_mosi;
                rx_cnt = rx_cnt + 1;
            end else begin
                tx_cnt = tx_cnt + 1;
            end
        end
        if (prev_act && !cs_act) cs_rel = cs_rel + 1;
        prev_sclk = spi_sclk;
        prev_act  = cs_act;
    end

    // ---------------- helpers ----------------
    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic bus_rd(input logic [6:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic slv_clear();
        lead_cnt = 0; rx_cnt = 0; tx_cnt = 0; cs_rel = 0;
    endtask

    task automatic cfg(input bit din, input bit cpol, input bit cshigh, input bit hold, input int nbytes);
        bus_wr(7'h1C, (32'(cpol) << 7) | 32'(din));
        bus_wr(7'h2C, (32'(hold) << 30) | (32'(cshigh) << 23));
        bus_wr(7'h20, 32'(8 * nbytes - 1) << 17);
        bus_wr(7'h30, 32'h0);
        tb_cpol = cpol; tb_cshigh = cshigh;
        @(negedge clk);
        @(negedge clk);
        slv_clear();
    endtask

    task automatic go();
        bus_wr(7'h00, 32'h1 << 18);
    endtask

    task automatic wait_done(input string req);
        logic [31:0] r;
        bit ok = 0;
        for (int i = 0; i < 20000; i++) begin
            bus_rd(7'h30, r);
            if (r[4]) begin ok = 1; break; end
        end
        chk(req, 32'(ok), 32'h1);
    endtask

    function automatic logic [31:0] rx_word(input int w);
        return {slv_rx[4*w+3], slv_rx[4*w+2], slv_rx[4*w+1], slv_rx[4*w]};
    endfunction

    // ---------------- scenarios ----------------
    task automatic t_reset();
        logic [31:0] r;
        bus_rd(7'h30, r);
        chk("R5 done clear after reset", r, 32'h0);
        chk("R7 cs idle high (active-low)", 32'(spi_cs), 32'h1);
        chk("R8 sclk idle low", 32'(spi_sclk), 32'h0);
    endtask

    task automatic t_basic();
        logic [31:0] r;
        cfg(1, 0, 0, 0, 4);
        bus_wr(7'h40, 32'h810F3CA5);
        slv_tx[0] = 8'h12; slv_tx[1] = 8'h34; slv_tx[2] = 8'h56; slv_tx[3] = 8'h78;
        go();
        chk("R2 cs active after start", 32'(spi_cs), 32'h0);
        wait_done("R5 done set");
        chk("R1 slave got bytes lane order MSB first", rx_word(0), 32'h810F3CA5);
        chk("R3 leading edges for 4 bytes", 32'(lead_cnt), 32'd32);
        bus_rd(7'h40, r);
        chk("R4 captured MISO in buffer", r, 32'h78563412);
        chk("R6 cs released without hold", 32'(spi_cs), 32'h1);
        bus_wr(7'h30, 32'h0);
        bus_rd(7'h30, r);
        chk("R5 done cleared by write", r, 32'h0);
    endtask

    task automatic t_partial();
        logic [31:0] r;
        cfg(1, 0, 0, 0, 1);
        bus_wr(7'h40, 32'hDDCCBBAA);
        slv_tx[0] = 8'h5A;
        go();
        wait_done("R3 done one byte");
        chk("R3 leading edges for 1 byte", 32'(lead_cnt), 32'd8);
        bus_rd(7'h40, r);
        chk("R3 only byte 0 replaced", r, 32'hDDCCBB5A);
        chk("R1 single byte sent", 32'(slv_rx[0]), 32'hAA);
    endtask

    task automatic t_nodin();
        logic [31:0] r;
        cfg(0, 0, 0, 0, 8);
        bus_wr(7'h40, 32'h01020304);
        bus_wr(7'h44, 32'hCAFEF00D);
        for (int i = 0; i < 8; i++) slv_tx[i] = 8'hFF;
        go();
        wait_done("R4 done no capture");
        bus_rd(7'h40, r);
        chk("R4 word0 kept", r, 32'h01020304);
        bus_rd(7'h44, r);
        chk("R4 word1 kept", r, 32'hCAFEF00D);
        chk("R1 second word bytes sent", rx_word(1), 32'hCAFEF00D);
    endtask

    task automatic t_pol();
        logic [31:0] r;
        cfg(1, 1, 1, 0, 2);
        chk("R8 sclk idles high", 32'(spi_sclk), 32'h1);
        chk("R7 cs idles low when active-high", 32'(spi_cs), 32'h0);
        bus_wr(7'h40, 32'h0000C3E7);
        slv_tx[0] = 8'h99; slv_tx[1] = 8'h66;
        go();
        chk("R7 cs high while active", 32'(spi_cs), 32'h1);
        wait_done("R8 done inverted clock");
        chk("R9 bytes sent with cpol=1", {16'h0, slv_rx[1], slv_rx[0]}, 32'h0000C3E7);
        bus_rd(7'h40, r);
        chk("R9 bytes captured with cpol=1", r, 32'h00006699);
        chk("R8 sclk back high", 32'(spi_sclk), 32'h1);
        cfg(1, 0, 0, 0, 1);
    endtask

    task automatic t_hold();
        logic [31:0] r;
        cfg(1, 0, 0, 1, 2);
        bus_wr(7'h40, 32'h00002211);
        slv_tx[0] = 8'hA1; slv_tx[1] = 8'hB2; slv_tx[2] = 8'hC3; slv_tx[3] = 8'hD4;
        go();
        wait_done("R6 chunk 1 done");
        chk("R6 cs held after chunk", 32'(spi_cs), 32'h0);
        bus_rd(7'h40, r);
        chk("R6 chunk 1 data", r, 32'h0000B2A1);
        bus_wr(7'h2C, 32'h0);
        bus_wr(7'h30, 32'h0);
        bus_wr(7'h40, 32'h00004433);
        go();
        wait_done("R6 chunk 2 done");
        chk("R6 one select window", 32'(cs_rel), 32'd1);
        chk("R6 continuous stream", rx_word(0), 32'h44332211);
        bus_rd(7'h40, r);
        chk("R6 chunk 2 data", r, 32'h0000D4C3);
    endtask

    task automatic t_busy();
        cfg(1, 0, 0, 0, 4);
        go();
        repeat (20) @(negedge clk);
        go();
        wait_done("R12 done");
        chk("R12 restart ignored, edge count", 32'(lead_cnt), 32'd32);
        repeat (30) @(negedge clk);
        chk("R12 no second transfer", 32'(lead_cnt), 32'd32);
    endtask

    task automatic t_mode();
        logic [31:0] r;
        cfg(1, 0, 0, 0, 1);
        bus_wr(7'h30, 32'h1 << 30);
        bus_rd(7'h30, r);
        chk("R11 mode bit readback", r, 32'h40000000);
        go();
        repeat (20) @(negedge clk);
        chk("R11 no cs in non-master mode", 32'(spi_cs), 32'h1);
        chk("R11 no clocks", 32'(lead_cnt), 32'd0);
        bus_wr(7'h30, 32'h0);
    endtask

    task automatic t_srst();
        logic [31:0] r;
        int snap;
        cfg(1, 0, 0, 1, 64);
        go();
        repeat (100) @(negedge clk);
        bus_wr(7'h30, 32'h1 << 31);
        chk("R10 cs released by soft reset", 32'(spi_cs), 32'h1);
        chk("R10 sclk idle after soft reset", 32'(spi_sclk), 32'h0);
        bus_rd(7'h30, r);
        chk("R10 reset bit self-clears, not done", r, 32'h0);
        snap = lead_cnt;
        repeat (40) @(negedge clk);
        chk("R10 no clocks after soft reset", 32'(lead_cnt), 32'(snap));
    endtask

    task automatic t_full();
        logic [31:0] r;
        int bad;
        cfg(1, 0, 0, 0, 64);
        for (int w = 0; w < 16; w++)
            bus_wr(7'h40 + 7'(4 * w), {8'((4*w+3)*7+3), 8'((4*w+2)*7+3), 8'((4*w+1)*7+3), 8'((4*w)*7+3)});
        for (int i = 0; i < 64; i++) slv_tx[i] = ~8'(i * 5);
        go();
        wait_done("R3 done 64 bytes");
        chk("R3 leading edges for 64 bytes", 32'(lead_cnt), 32'd512);
        bad = 0;
        for (int i = 0; i < 64; i++) if (slv_rx[i] !== 8'(i * 7 + 3)) bad++;
        chk("R1 all 64 bytes sent in order", 32'(bad), 32'd0);
        bad = 0;
        for (int w = 0; w < 16; w++) begin
            bus_rd(7'h40 + 7'(4 * w), r);
            if (r !== {slv_tx[4*w+3], slv_tx[4*w+2], slv_tx[4*w+1], slv_tx[4*w]}) bad++;
        end
        chk("R4 all 64 bytes captured", 32'(bad), 32'd0);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) begin slv_tx[i] = 8'h00; slv_rx[i] = 8'h00; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_partial();
        t_nodin();
        t_pol();
        t_hold();
        t_busy();
        t_mode();
        t_srst();
        t_full();
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule